// File: doc/BRIEF.md
# ODT Minimum High-Time Checker

This protocol monitor watches a memory controller's on-die termination request as the device registers it, together with the write-command strobe and a flag giving the burst length of each write. It raises an alarm when the controller drops the termination request sooner than the device's minimum high-time rules allow. It is placed beside the command path in simulation or in silicon and has no effect on the traffic it observes.

Two references are tracked independently. The first is the clock on which the request was registered high. The second is the most demanding write registered while the request was high. When the request is registered low, the monitor compares the elapsed clocks against each pending minimum. On an early drop it emits a one-cycle pulse carrying a code that names the broken rule, and it sets a sticky flag that only reset clears.

Top module: `odt_hold_checker`

## Requirements
- R1: If `odt_reg` goes from 0 to 1 at clock t0 and returns to 0 at clock t1 with t1 - t0 < 4, and no write rule is pending, the violation code at clock t1 is 2'b01. If t1 - t0 >= 4, this rule flags nothing.
- R2: A write with `wr_bl8`=0 (burst chop 4) registered at clock tw while `odt_reg`=1 requires `odt_reg` to stay 1 until a clock t1 with t1 - tw >= 4. An earlier drop gives code 2'b10.
- R3: A write with `wr_bl8`=1 (burst 8) registered at clock tw while `odt_reg`=1 requires t1 - tw >= 6. An earlier drop gives code 2'b11.
- R4: A write registered while `odt_reg`=0 starts no requirement and produces no pulse. This includes a write on the very clock the request is registered low.
- R5: `viol_pulse` is 1 only during the clock on which `odt_reg` is registered low too early, in the same cycle as that input. In that cycle `viol_code` is nonzero. In every other cycle the pulse is 0 and the code is 2'b00.
- R6: When several qualifying writes fall in one high period, the write with the latest deadline (tw plus its minimum) governs. On equal deadlines the newer write governs, including for the code.
- R7: When both a write rule and the assertion rule are unmet at the drop, the write code (2'b10 or 2'b11) is reported.
- R8: `viol_sticky` becomes 1 on the clock after the first violation pulse and stays 1 until `rst_n` is asserted. It is 0 while `rst_n` is low.
- R9: Across reset the request is taken to have been low. If `odt_reg` is 1 on the first clock after reset release, that clock starts a fresh assertion check.
- R10: A high period of any length, including hundreds of clocks, raises no violation once its minimums are met. Internal counts never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odt_reg | input | 1 | Termination request as registered by the device on this clock |
| wr_valid | input | 1 | A write command is registered on this clock |
| wr_bl8 | input | 1 | Burst length of the write: 1 = burst 8, 0 = burst chop 4 |
| viol_pulse | output | 1 | One-cycle flag on an early drop of the request |
| viol_code | output | 2 | Rule broken: 01 assertion, 10 chop-4 write, 11 burst-8 write, 00 none |
| viol_sticky | output | 1 | Set after any violation, cleared only by reset |

## Verification
Every internal state shows up at the ports when the request falls. A remaining-time counter that is off by one moves the boundary between a legal and an illegal high length by one clock. A wrong merge of overlapping writes shows as a wrong code, or as a missing pulse at a drop placed just inside the stronger deadline. The bench sweeps every high length from 1 to 8 with every placement and kind of one or two writes. Each error therefore shows at the first drop clock that crosses the affected deadline, in the same cycle, and one clock later on the sticky flag.

// File: rtl/odt_chk_pkg.sv
package odt_chk_pkg;

  typedef enum logic [1:0] {
    VIOL_NONE   = 2'b00,
    VIOL_ASSERT = 2'b01,
    VIOL_WR_BC4 = 2'b10,
    VIOL_WR_BL8 = 2'b11
  } viol_code_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/odt_assert_timer.sv
module odt_assert_timer
  import odt_chk_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic odt_smp,
  input  logic odt_rise,
  output logic pending
);

  localparam int unsigned CW = cnt_width(MIN_HIGH);
  localparam logic [CW-1:0] LOAD = CW'(MIN_HIGH - 1);

  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    rem_d = rem_q;
    if (!odt_smp)            rem_d = '0;
    else if (odt_rise)       rem_d = LOAD;
    else if (rem_q != '0)    rem_d = rem_q - 1'b1;
    rem_en = (rem_d != rem_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign pending = (rem_q != '0);

  assert_pend_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $past(odt_smp));

  assert_rem_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= LOAD);

endmodule

// File: rtl/odt_write_timer.sv
module odt_write_timer
  import odt_chk_pkg::*;
#(
  parameter int unsigned BC4_HIGH = 4,
  parameter int unsigned BL8_HIGH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic odt_smp,
  input  logic wr_qual,
  input  logic wr_bl8,
  output logic pending,
  output logic pend_bl8
);

  localparam int unsigned LONGEST = (BL8_HIGH > BC4_HIGH) ? BL8_HIGH : BC4_HIGH;
  localparam int unsigned CW = cnt_width(LONGEST);
  localparam logic [CW-1:0] BC4_LOAD = CW'(BC4_HIGH - 1);
  localparam logic [CW-1:0] BL8_LOAD = CW'(BL8_HIGH - 1);
  localparam logic [CW-1:0] MAX_LOAD = CW'(LONGEST - 1);

  logic [CW-1:0] rem_q, rem_d, rem_dec, new_load;
  logic          kind_q, kind_d;
  logic          st_en;

  always_comb begin
    rem_dec  = (rem_q == '0) ? '0 : rem_q - 1'b1;
    new_load = wr_bl8 ? BL8_LOAD : BC4_LOAD;
    rem_d    = rem_q;
    kind_d   = kind_q;
    if (!odt_smp) begin
      rem_d  = '0;
      kind_d = 1'b0;
    end else if (wr_qual && (new_load >= rem_dec)) begin
      rem_d  = new_load;
      kind_d = wr_bl8;
    end else begin
      rem_d  = rem_dec;
    end
    st_en = (rem_d != rem_q) || (kind_d != kind_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      kind_q <= 1'b0;
    end else if (st_en) begin
      rem_q  <= rem_d;
      kind_q <= kind_d;
    end
  end

  assign pending  = (rem_q != '0);
  assign pend_bl8 = kind_q;

  assert_low_clears_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !odt_smp |=> !pending);

  assert_bl8_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_qual && wr_bl8) |=> (rem_q >= BL8_LOAD));

  assert_write_rem_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= MAX_LOAD);

endmodule

// File: rtl/odt_hold_checker.sv
module odt_hold_checker
  import odt_chk_pkg::*;
#(
  parameter int unsigned ASSERT_HIGH = 4,
  parameter int unsigned BC4_HIGH    = 4,
  parameter int unsigned BL8_HIGH    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odt_reg,
  input  logic       wr_valid,
  input  logic       wr_bl8,
  output logic       viol_pulse,
  output logic [1:0] viol_code,
  output logic       viol_sticky
);

  logic       odt_q;
  logic       odt_rise, odt_fall, wr_qual;
  logic       as_pend, wr_pend, wr_pend_bl8;
  viol_code_e code_d;
  logic       sticky_d;

  assign odt_rise = odt_reg && !odt_q;
  assign odt_fall = !odt_reg && odt_q;
  assign wr_qual  = wr_valid && odt_reg;

  odt_assert_timer #(.MIN_HIGH(ASSERT_HIGH)) u_assert_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .odt_smp  (odt_reg),
    .odt_rise (odt_rise),
    .pending  (as_pend)
  );

  odt_write_timer #(.BC4_HIGH(BC4_HIGH), .BL8_HIGH(BL8_HIGH)) u_write_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .odt_smp  (odt_reg),
    .wr_qual  (wr_qual),
    .wr_bl8   (wr_bl8),
    .pending  (wr_pend),
    .pend_bl8 (wr_pend_bl8)
  );

  always_comb begin
    code_d = VIOL_NONE;
    if (odt_fall) begin
      if (wr_pend)      code_d = wr_pend_bl8 ? VIOL_WR_BL8 : VIOL_WR_BC4;
      else if (as_pend) code_d = VIOL_ASSERT;
    end
    sticky_d = viol_sticky | (code_d != VIOL_NONE);
  end

  assign viol_code  = code_d;
  assign viol_pulse = (code_d != VIOL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odt_q       <= 1'b0;
      viol_sticky <= 1'b0;
    end else begin
      odt_q <= odt_reg;
      if (viol_pulse) viol_sticky <= sticky_d;
    end
  end

  assert_pulse_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (!odt_reg && $past(odt_reg)));

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> viol_sticky);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_sticky |=> viol_sticky);

  assert_code_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    odt_reg |-> (viol_code == 2'b00));

endmodule

// File: tb/odt_hold_checker_bench.sv
`timescale 1ns/1ps
module odt_hold_checker_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       odt_reg, wr_valid, wr_bl8;
  logic       viol_pulse, viol_sticky;
  logic [1:0] viol_code;

  int checks = 0;
  int errors = 0;
  logic exp_sticky = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  odt_hold_checker u_odt_hold_checker (
    .clk(clk), .rst_n(rst_n), .odt_reg(odt_reg), .wr_valid(wr_valid),
    .wr_bl8(wr_bl8), .viol_pulse(viol_pulse), .viol_code(viol_code),
    .viol_sticky(viol_sticky)
  );

  task automatic check_now(input logic [1:0] exp_code, input string req);
    checks++;
    if (viol_pulse !== (exp_code != 2'b00) || viol_code !== exp_code ||
        viol_sticky !== exp_sticky) begin
      errors++;
      $display("FAIL %s pulse=%b code=%b sticky=%b expected pulse=%b code=%b sticky=%b",
               req, viol_pulse, viol_code, viol_sticky,
               (exp_code != 2'b00), exp_code, exp_sticky);
    end
    if (exp_code != 2'b00) exp_sticky = 1'b1;
  endtask

  task automatic step(input logic o, input logic w, input logic b,
                      input logic [1:0] exp_code, input string req);
    @(negedge clk);
    odt_reg = o; wr_valid = w; wr_bl8 = b;
    #2;
    check_now(exp_code, req);
  endtask

  // One high period of length len with up to two writes at high-cycle indices
  task automatic run_trial(input int len, input bit w1, input int k1, input bit b1,
                           input bit w2, input int k2, input bit b2);
    int end1, end2, gend;
    bit gkind, gvalid;
    logic [1:0] exp;
    string req;
    end1 = k1 + (b1 ? 6 : 4);
    end2 = k2 + (b2 ? 6 : 4);
    gvalid = 1'b0; gend = 0; gkind = 1'b0;
    if (w1) begin gvalid = 1'b1; gend = end1; gkind = b1; end
    if (w2 && (!w1 || end2 >= end1)) begin gvalid = 1'b1; gend = end2; gkind = b2; end
    if (gvalid && gend > len) exp = gkind ? 2'b11 : 2'b10;
    else if (len < 4)         exp = 2'b01;
    else                      exp = 2'b00;
    if (w2)                 req = "R6";
    else if (exp == 2'b11)  req = "R3";
    else if (exp == 2'b10)  req = (len < 4) ? "R7" : "R2";
    else if (exp == 2'b01)  req = "R1";
    else                    req = "R5";
    step(1'b0, 1'b1, 1'b1, 2'b00, "R4");
    for (int i = 0; i < len; i++) begin
      logic wr, bl;
      wr = (w1 && i == k1) || (w2 && i == k2);
      bl = (w2 && i == k2) ? b2 : b1;
      step(1'b1, wr, bl, 2'b00, "R5");
    end
    step(1'b0, 1'b1, 1'b1, exp, req);
    step(1'b0, 1'b0, 1'b0, 2'b00, "R5");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; odt_reg = 1'b0; wr_valid = 1'b0; wr_bl8 = 1'b0;
    #3;
    check_now(2'b00, "R8 reset state");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 2'b00, "R5");

    // Sweep: high lengths 1..8, every one- and two-write placement
    for (int len = 1; len <= 8; len++) begin
      run_trial(len, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
      for (int a = 0; a < 2 * len; a++) begin
        run_trial(len, 1'b1, a / 2, a[0], 1'b0, 0, 1'b0);
        for (int c = 2 * (a / 2 + 1); c < 2 * len; c++)
          run_trial(len, 1'b1, a / 2, a[0], 1'b1, c / 2, c[0]);
      end
    end

    // R10: long high periods, no wrap and correct boundary
    run_trial(300, 1'b1, 0, 1'b1, 1'b1, 296, 1'b0);
    run_trial(300, 1'b1, 0, 1'b1, 1'b1, 297, 1'b1);
    run_trial(300, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    check_now(2'b00, "R10 long high no wrap");

    // R8: reset clears sticky; R9: high at release is a fresh rise
    @(negedge clk);
    rst_n = 1'b0; odt_reg = 1'b1; wr_valid = 1'b0;
    #2;
    exp_sticky = 1'b0;
    check_now(2'b00, "R8 cleared by reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 2'b00, "R9");
    step(1'b0, 1'b0, 1'b0, 2'b01, "R9 fresh rise after reset");
    step(1'b0, 1'b0, 1'b0, 2'b00, "R8 sticky set after pulse");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule